// File: doc/BRIEF.md
# Streaming Cell Key Rewriter

This block sits in a cell stream, 32 bits per word, with a strobe that marks the first word of each cell. Each cell is 14 words long: two header words, then twelve payload words that hold 48 bytes. The first header word carries a virtual path field in bits [31:20], a virtual channel field in bits [19:4] and a payload type in bits [3:0]. The second header word holds a check byte and padding. The block does not interpret the second header word.

When a cell arrives on the selected channel and its payload opens with the five-byte ASCII key "HELLO", the block overwrites the payload bytes that follow. The result is that the payload reads "HELLO WORLD.". Every other cell, and every other word, leaves the block unchanged, two clock cycles after it entered.

The input and the output edges are registered. A downstream flow-control ready is carried back upstream through the same two register stages. The block takes back-to-back cells with no idle cycle between them.

Top module: `cell_key_rewriter`

## Requirements
- R1: Every input word appears on `out_data` exactly two clock edges after it is sampled on `in_data`, and `out_soc` carries the start-of-cell strobe with the same two-edge delay, so it stays aligned with header word 0.
- R2: Only a cell whose header word 0 has channel field bits [19:4] equal to 5 is a candidate. A cell on any other channel value, including 0x0105, leaves the block with every word unchanged.
- R3: Payload word 0 (cell word index 2) must equal 0x48454C4C. Otherwise the whole cell is copied unchanged; for example, 0x4D454C4C ("MELL") is not rewritten.
- R4: Bits [31:24] of payload word 1 (cell word index 3) must equal 0x4F. Otherwise the cell is copied unchanged; for example, a fifth byte of 0x50 is not rewritten.
- R5: On a full match, bits [23:0] of cell word 3 become 0x20574F, bits [31:24] of that word are kept, and cell word 4 becomes 0x524C442E.
- R6: Both header words, the key words, all payload words from cell word 5 on, and idle words between cells pass through unchanged.
- R7: Cells presented back to back, with no idle cycle between them, are each judged and rewritten on their own.
- R8: A start-of-cell strobe always restarts processing at header word 0, even when the previous cell was cut short. Rewriting that had not yet been done for the cut cell is dropped.
- R9: `up_ready` equals `dn_ready` delayed by two clock edges.
- R10: While `rst_n` is low, `out_data`, `out_soc` and `up_ready` are 0. After reset, a word that arrives without a start-of-cell strobe is never rewritten.
- R11: The path field and the payload-type field of header word 0 do not affect matching: a cell with channel 5, path 0xABC and type 0xF is rewritten like any other candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 32 | Incoming cell word |
| in_soc | input | 1 | High with the first header word of a cell |
| up_ready | output | 1 | Flow-control ready sent upstream |
| out_data | output | 32 | Outgoing cell word, possibly rewritten |
| out_soc | output | 1 | Start-of-cell strobe aligned with out_data |
| dn_ready | input | 1 | Flow-control ready from downstream |

## Verification
The bench sends cells that fail the match at each stage: wrong channel (including 0x0105, whose low nibble is still 5), a wrong first key word, and a wrong fifth byte. A design that checked only part of a field, or checked one stage too few, would rewrite words 3 and 4 of these cells. Cells cut short after word 3 or after word 2, each followed at once by a new strobe, catch a controller that fails to restart on the strobe; such a controller would rewrite the new cell's header or miss its key. A reset in the middle of a candidate cell, followed by a key-like word without a strobe, shows whether reset really returns the block to pass-through. Back-to-back cells and idle words between cells expose a position counter that is off by one or that fails to hold outside a cell.

// File: rtl/ckr_pkg.sv
package ckr_pkg;

    typedef enum logic [2:0] {
        ST_RST   = 3'd0,
        ST_PASS  = 3'd1,
        ST_KEY   = 3'd2,
        ST_TAIL  = 3'd3,
        ST_WRITE = 3'd4
    } ckr_state_e;

    localparam int CHAN_LSB = 4;
    localparam int CHAN_W   = 16;

endpackage

// File: rtl/ckr_edge_reg.sv
module ckr_edge_reg #(
    parameter int W = 34
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] r_d, r_q;

    always_comb begin
        r_d = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign q = r_q;
endmodule

// File: rtl/ckr_ctrl.sv
module ckr_ctrl
    import ckr_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          CELL_WORDS = 14,
    parameter int          HDR_WORDS  = 2,
    parameter logic [15:0] CHAN_SEL   = 16'd5,
    parameter logic [31:0] KEY_WORD   = 32'h48454C4C,
    parameter logic [7:0]  KEY_TAIL   = 8'h4F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soc,
    input  logic [DATA_W-1:0] word,
    output logic              do_tail,
    output logic              do_word
);
    localparam int CNT_W     = $clog2(CELL_WORDS + 1);
    localparam int POS_KEY   = HDR_WORDS;
    localparam int POS_TAIL  = HDR_WORDS + 1;
    localparam int POS_WRITE = HDR_WORDS + 2;

    typedef struct packed {
        ckr_state_e       state;
        logic [CNT_W-1:0] cnt;
    } ctrl_s;

    ctrl_s c_d, c_q;
    logic [CNT_W-1:0] pos;
    logic             chan_hit;
    logic             key_hit;
    logic             tail_hit;

    always_comb begin
        pos      = soc ? '0 : c_q.cnt;
        chan_hit = (word[CHAN_LSB +: CHAN_W] == CHAN_SEL);
        key_hit  = (word == KEY_WORD);
        tail_hit = (word[DATA_W-1 -: 8] == KEY_TAIL);

        c_d     = c_q;
        do_tail = 1'b0;
        do_word = 1'b0;

        if (pos != CNT_W'(CELL_WORDS)) c_d.cnt = pos + 1'b1;
        else                           c_d.cnt = pos;

        if (soc) begin
            c_d.state = chan_hit ? ST_KEY : ST_PASS;
        end else begin
            unique case (c_q.state)
                ST_KEY: begin
                    if (pos == CNT_W'(POS_KEY))
                        c_d.state = key_hit ? ST_TAIL : ST_PASS;
                end
                ST_TAIL: begin
                    if (pos == CNT_W'(POS_TAIL)) begin
                        do_tail   = tail_hit;
                        c_d.state = tail_hit ? ST_WRITE : ST_PASS;
                    end
                end
                ST_WRITE: begin
                    if (pos == CNT_W'(POS_WRITE)) begin
                        do_word   = 1'b1;
                        c_d.state = ST_PASS;
                    end
                end
                default: c_d.state = c_q.state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state <= ST_RST;
            c_q.cnt   <= CNT_W'(CELL_WORDS);
        end else begin
            c_q <= c_d;
        end
    end

    // R1: the position counter never runs past the cell length
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.cnt <= CNT_W'(CELL_WORDS));

    // R8: a strobe always restarts at header word 0
    a_r8_soc_restart: assert property (@(posedge clk) disable iff (!rst_n)
        soc |=> (c_q.cnt == CNT_W'(1)));

    // R2: an off-channel header drops the cell to pass-through
    a_r2_off_channel: assert property (@(posedge clk) disable iff (!rst_n)
        (soc && !chan_hit) |=> (c_q.state == ST_PASS));

    // R5: the full-word rewrite only follows a successful tail check
    a_r5_write_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_WRITE) |-> ($past(c_q.state) == ST_TAIL));

    // R5: at most one rewrite kind per word
    a_r5_one_rewrite: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_tail, do_word}));

    // R10: reset leaves the block in a state that rewrites nothing
    a_r10_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_RST) |-> (!do_tail && !do_word));
endmodule

// File: rtl/ckr_rewrite.sv
module ckr_rewrite #(
    parameter int          DATA_W    = 32,
    parameter logic [23:0] REPL_LO   = 24'h20574F,
    parameter logic [31:0] REPL_WORD = 32'h524C442E
) (
    input  logic              do_tail,
    input  logic              do_word,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] word_o
);
    localparam int LO_W = DATA_W - 8;

    always_comb begin
        if (do_word)      word_o = REPL_WORD;
        else if (do_tail) word_o = {word_i[DATA_W-1 -: 8], REPL_LO[LO_W-1:0]};
        else              word_o = word_i;
    end
endmodule

// File: rtl/cell_key_rewriter.sv
module cell_key_rewriter
    import ckr_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          CELL_WORDS = 14,
    parameter int          HDR_WORDS  = 2,
    parameter logic [15:0] CHAN_SEL   = 16'd5,
    parameter logic [31:0] KEY_WORD   = 32'h48454C4C,
    parameter logic [7:0]  KEY_TAIL   = 8'h4F,
    parameter logic [23:0] REPL_LO    = 24'h20574F,
    parameter logic [31:0] REPL_WORD  = 32'h524C442E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_soc,
    output logic              up_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_soc,
    input  logic              dn_ready
);
    localparam int EDGE_W = DATA_W + 2;

    logic [EDGE_W-1:0] in_bus, in_q, out_bus, out_q;
    logic [DATA_W-1:0] rw_data;
    logic              do_tail, do_word;

    assign in_bus = {in_soc, dn_ready, in_data};

    ckr_edge_reg #(.W(EDGE_W)) u_in_edge (
        .clk(clk), .rst_n(rst_n), .d(in_bus), .q(in_q)
    );

    ckr_ctrl #(
        .DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS), .HDR_WORDS(HDR_WORDS),
        .CHAN_SEL(CHAN_SEL), .KEY_WORD(KEY_WORD), .KEY_TAIL(KEY_TAIL)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .soc(in_q[EDGE_W-1]), .word(in_q[DATA_W-1:0]),
        .do_tail(do_tail), .do_word(do_word)
    );

    ckr_rewrite #(
        .DATA_W(DATA_W), .REPL_LO(REPL_LO), .REPL_WORD(REPL_WORD)
    ) u_rewrite (
        .do_tail(do_tail), .do_word(do_word),
        .word_i(in_q[DATA_W-1:0]), .word_o(rw_data)
    );

    assign out_bus = {in_q[EDGE_W-1], in_q[DATA_W], rw_data};

    ckr_edge_reg #(.W(EDGE_W)) u_out_edge (
        .clk(clk), .rst_n(rst_n), .d(out_bus), .q(out_q)
    );

    assign out_soc  = out_q[EDGE_W-1];
    assign up_ready = out_q[DATA_W];
    assign out_data = out_q[DATA_W-1:0];

    // Cycles since reset, saturating; gates the delay checks below.
    logic [1:0] warm_d, warm_q;
    always_comb warm_d = (warm_q == 2'd2) ? warm_q : warm_q + 2'd1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= '0;
        else        warm_q <= warm_d;
    end

    // R1: start-of-cell strobe delayed by two edges
    a_r1_soc_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (out_soc == $past(in_soc, 2)));

    // R9: ready carried upstream with two edges of delay
    a_r9_ready_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (up_ready == $past(dn_ready, 2)));

    // R6: words not flagged for rewrite leave unchanged
    a_r6_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_tail && !do_word) |=> (out_data == $past(in_q[DATA_W-1:0])));

    // R10: reset clears the output edge
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (out_data == '0 && !out_soc && !up_ready));
endmodule

// File: tb/cell_key_rewriter_bench.sv
module cell_key_rewriter_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] in_data;
    logic        in_soc;
    logic        dn_ready;
    logic        up_ready;
    logic [31:0] out_data;
    logic        out_soc;

    always #5 clk = ~clk;

    cell_key_rewriter u_cell_key_rewriter (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_soc(in_soc),
        .up_ready(up_ready), .out_data(out_data), .out_soc(out_soc),
        .dn_ready(dn_ready)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [31:0] pe_data [2];
    logic        pe_soc  [2];
    logic        pe_rdy  [2];
    logic        pe_v    [2];
    string       pe_tag  [2];

    localparam int NV = 9;
    localparam logic [31:0] T_HDR [NV] = '{32'h00000050, 32'h00000060, 32'h00000050,
        32'h00000050, 32'hABC0005F, 32'h00001050, 32'h00000050, 32'h00000050, 32'h00000050};
    localparam logic [31:0] T_P0 [NV] = '{32'h48454C4C, 32'h48454C4C, 32'h4D454C4C,
        32'h48454C4C, 32'h48454C4C, 32'h48454C4C, 32'h48454C4C, 32'h48454C4C, 32'h48454C4C};
    localparam logic [31:0] T_P1 [NV] = '{32'h4F202020, 32'h4F202020, 32'h4F202020,
        32'h50202020, 32'h4F414243, 32'h4F202020, 32'h4F202020, 32'h4F202020, 32'h4F202020};
    localparam int T_LEN [NV] = '{14, 14, 14, 14, 14, 14, 4, 3, 14};
    localparam int T_GAP [NV] = '{0, 0, 2, 0, 0, 1, 0, 0, 3};

    function automatic string tag_of(input int i);
        case (i)
            0: return "R5";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R11";
            5: return "R2";
            6: return "R8";
            7: return "R8";
            default: return "R7";
        endcase
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic flush();
        pe_v[0] = 1'b0;
        pe_v[1] = 1'b0;
    endtask

    task automatic drive_word(input logic [31:0] d, input logic s,
                              input logic [31:0] ed, input string tag);
        logic r;
        @(negedge clk);
        if (pe_v[1]) begin
            check(pe_tag[1], out_data, pe_data[1]);
            check("R1", {31'd0, out_soc}, {31'd0, pe_soc[1]});
            check("R9", {31'd0, up_ready}, {31'd0, pe_rdy[1]});
        end
        r = (cyc % 3) != 0;
        pe_data[1] = pe_data[0]; pe_soc[1] = pe_soc[0];
        pe_rdy[1]  = pe_rdy[0];  pe_v[1]   = pe_v[0];  pe_tag[1] = pe_tag[0];
        pe_data[0] = ed; pe_soc[0] = s; pe_rdy[0] = r; pe_v[0] = 1'b1; pe_tag[0] = tag;
        in_data  = d;
        in_soc   = s;
        dn_ready = r;
    endtask

    task automatic send_cell(input int id, input logic [31:0] hdr, input logic [31:0] p0,
                             input logic [31:0] p1, input int len, input string tag);
        bit m;
        m = (hdr[19:4] == 16'd5) && (p0 == 32'h48454C4C) && (p1[31:24] == 8'h4F);
        for (int k = 0; k < len; k++) begin
            logic [31:0] w, e;
            string t;
            case (k)
                0: w = hdr;
                1: w = 32'hC3000000;
                2: w = p0;
                3: w = p1;
                4: w = 32'h45454F20;
                default: w = 32'h5A000000 | (32'(k) << 8) | 32'(id);
            endcase
            e = w;
            t = (k >= 5) ? "R6" : tag;
            if (m && k == 3) e = {w[31:24], 24'h20574F};
            if (m && k == 4) e = 32'h524C442E;
            if (k == 0) t = "R1";
            drive_word(w, (k == 0), e, t);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            drive_word(32'h0BAD0000 + 32'(i), 1'b0, 32'h0BAD0000 + 32'(i), "R6");
    endtask

    task automatic reset_check();
        @(negedge clk);
        rst_n = 1'b0;
        flush();
        @(negedge clk);
        check("R10", out_data, 32'h0);
        check("R10", {31'd0, out_soc}, 32'h0);
        check("R10", {31'd0, up_ready}, 32'h0);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; in_data = '0; in_soc = 1'b0; dn_ready = 1'b0;
        flush();
        repeat (3) @(negedge clk);
        check("R10", out_data, 32'h0);
        check("R10", {31'd0, out_soc}, 32'h0);
        check("R10", {31'd0, up_ready}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            send_cell(i, T_HDR[i], T_P0[i], T_P1[i], T_LEN[i], tag_of(i));
            idle(T_GAP[i]);
        end
        idle(2);

        // R10: reset in the middle of a candidate cell, then key-like words without a strobe
        drive_word(32'h00000050, 1'b1, 32'h00000050, "R1");
        drive_word(32'hC3000000, 1'b0, 32'hC3000000, "R6");
        drive_word(32'h48454C4C, 1'b0, 32'h48454C4C, "R6");
        reset_check();
        drive_word(32'h4F202020, 1'b0, 32'h4F202020, "R10");
        drive_word(32'h45454F20, 1'b0, 32'h45454F20, "R10");
        idle(2);

        // R7: two matching cells back to back after the reset
        send_cell(20, 32'h00000050, 32'h48454C4C, 32'h4F202020, 14, "R7");
        send_cell(21, 32'h00000050, 32'h48454C4C, 32'h4F202020, 14, "R7");
        idle(3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule